// File: doc/BRIEF.md
# DMA Channel Request-Enable Controller

This block keeps two per-channel bitmaps for a 16-channel DMA engine. The first bitmap gates each channel's hardware request line. The second enables each channel's error interrupt. A request passes to the engine only while its channel is enabled. An error interrupt rises only while the channel's error indicator and its interrupt enable are both high.

Software writes either bitmap as a whole word over a simple register bus, and reads either one back. Two dedicated ports change a single channel's error-interrupt enable without a read-modify-write. One port sets the bit and the other clears it, and each carries a channel number and a strobe. When the transfer engine reports that a channel has finished its major loop, and that channel's descriptor asks for its request to be disabled, the controller clears that channel's request enable by itself.

The block has no sequencing state. Every bit is a priority-encoded register, and both output vectors are combinational functions of those registers and the live inputs.

Top module: `dma_rqe_ctrl`

## Requirements
- R1: After reset, every request-enable bit and every error-interrupt-enable bit is 0. Reads of both registers return 0, and `req_out` and `err_irq` are 0.
- R2: A bus write to byte address 0x0C loads `bus_wr_data[15:0]` into the request enables, with channel n at bit n. A read at 0x0C returns the enables in bits [15:0]. Bits [31:16] always read 0, and the upper data bits of a write are ignored.
- R3: `req_out[n]` equals `hw_req[n]` while channel n's request enable is 1, and is 0 while it is 0.
- R4: A cycle with `major_done[n]` and `dis_req[n]` both 1 clears channel n's request enable at the next edge. With `dis_req[n]` at 0, the bit keeps its value.
- R5: If a bus write to 0x0C and an auto-clear of the same channel fall in the same cycle, the channel ends up cleared.
- R6: A bus write to byte address 0x14 loads `bus_wr_data[15:0]` into the error-interrupt enables, with channel n at bit n. A read at 0x14 returns them in bits [15:0].
- R7: A strobe on `eie_set_vld` makes the enable of channel `eie_set_ch` 1, and a strobe on `eie_clr_vld` makes the enable of channel `eie_clr_ch` 0. Both take effect at the next edge. When both strobes name the same channel in one cycle, the clear wins. When they name different channels, both take effect.
- R8: `err_irq[n]` is 1 exactly when `err_flag[n]` and channel n's error-interrupt enable are both 1.
- R9: Bus writes to any address other than 0x0C and 0x14 change neither bitmap. Reads of any other address return 0.
- R10: If a word write to 0x14 and a set or clear strobe fall in the same cycle, the strobe decides the bit of the channel it names. The written word decides all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_wr_addr | input | 8 | Bus write byte address |
| bus_wr_data | input | 32 | Bus write data |
| bus_rd_addr | input | 8 | Bus read byte address |
| bus_rd_data | output | 32 | Bus read data, combinational |
| eie_set_vld | input | 1 | Set strobe for one error-interrupt enable |
| eie_set_ch | input | 4 | Channel to set |
| eie_clr_vld | input | 1 | Clear strobe for one error-interrupt enable |
| eie_clr_ch | input | 4 | Channel to clear |
| hw_req | input | 16 | Raw hardware requests, one per channel |
| major_done | input | 16 | Major-loop completion pulses, one per channel |
| dis_req | input | 16 | Descriptor disable-request flag, one per channel |
| err_flag | input | 16 | Error indicators, one per channel |
| req_out | output | 16 | Gated requests to the engine |
| err_irq | output | 16 | Error interrupt requests |

## Verification
The assertions assume that every input is known after reset and changes only between clock edges. They also assume that a channel number on either single-channel port always names an implemented channel. The stimulus drives all inputs one time unit after a rising edge and holds them until the next edge. Channel numbers are drawn from the full 4-bit range, and 16 channels make every such value a legal channel. Collisions between the auto-clear and a word write, and between a strobe and a word write, are forced both on purpose and by random stimulus.

// File: rtl/dma_rqe_pkg.sv
`timescale 1ns/1ps
package dma_rqe_pkg;
    localparam int unsigned NCH_DEF    = 16;
    localparam int unsigned ADDR_W_DEF = 8;
    localparam int unsigned DATA_W_DEF = 32;

    localparam logic [ADDR_W_DEF-1:0] ADDR_REQEN = 8'h0C;
    localparam logic [ADDR_W_DEF-1:0] ADDR_ERRIE = 8'h14;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_REQEN = 2'd1,
        SEL_ERRIE = 2'd2
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W_DEF-1:0] a);
        unique case (a)
            ADDR_REQEN: return SEL_REQEN;
            ADDR_ERRIE: return SEL_ERRIE;
            default:    return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/dma_rqe_decode.sv
`timescale 1ns/1ps
module dma_rqe_decode
    import dma_rqe_pkg::*;
#(
    parameter int unsigned NCH    = NCH_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  logic                  wr_en,
    input  logic [ADDR_W_DEF-1:0] wr_addr,
    input  logic [ADDR_W_DEF-1:0] rd_addr,
    input  logic [NCH-1:0]        req_en,
    input  logic [NCH-1:0]        eie,
    output logic                  wr_reqen,
    output logic                  wr_errie,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int unsigned PAD_W = DATA_W - NCH;

    reg_sel_e wsel;
    reg_sel_e rsel;

    always_comb begin
        wsel     = decode_addr(wr_addr);
        wr_reqen = wr_en && (wsel == SEL_REQEN);
        wr_errie = wr_en && (wsel == SEL_ERRIE);
    end

    always_comb begin
        rsel = decode_addr(rd_addr);
        unique case (rsel)
            SEL_REQEN: rd_data = {{PAD_W{1'b0}}, req_en};
            SEL_ERRIE: rd_data = {{PAD_W{1'b0}}, eie};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dma_rqe_reqbank.sv
`timescale 1ns/1ps
module dma_rqe_reqbank #(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_reqen,
    input  logic [NCH-1:0] wr_bits,
    input  logic [NCH-1:0] major_done,
    input  logic [NCH-1:0] dis_req,
    input  logic [NCH-1:0] hw_req,
    output logic [NCH-1:0] req_en,
    output logic [NCH-1:0] req_out
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic auto_clr;
        assign auto_clr = major_done[g] & dis_req[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_en[g] <= 1'b0;
            end else if (auto_clr) begin
                req_en[g] <= 1'b0;
            end else if (wr_reqen) begin
                req_en[g] <= wr_bits[g];
            end
        end

        assign req_out[g] = hw_req[g] & req_en[g];
    end
endmodule

// File: rtl/dma_rqe_eiebank.sv
`timescale 1ns/1ps
module dma_rqe_eiebank #(
    parameter int unsigned NCH  = 16,
    parameter int unsigned CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_errie,
    input  logic [NCH-1:0]  wr_bits,
    input  logic            set_vld,
    input  logic [CH_W-1:0] set_ch,
    input  logic            clr_vld,
    input  logic [CH_W-1:0] clr_ch,
    input  logic [NCH-1:0]  err_flag,
    output logic [NCH-1:0]  eie,
    output logic [NCH-1:0]  err_irq
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic set_hit;
        logic clr_hit;
        assign set_hit = set_vld && (set_ch == CH_W'(g));
        assign clr_hit = clr_vld && (clr_ch == CH_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                eie[g] <= 1'b0;
            end else if (clr_hit) begin
                eie[g] <= 1'b0;
            end else if (set_hit) begin
                eie[g] <= 1'b1;
            end else if (wr_errie) begin
                eie[g] <= wr_bits[g];
            end
        end

        assign err_irq[g] = err_flag[g] & eie[g];
    end
endmodule

// File: rtl/dma_rqe_ctrl.sv
`timescale 1ns/1ps
module dma_rqe_ctrl
    import dma_rqe_pkg::*;
#(
    parameter int unsigned NCH    = NCH_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned CH_W   = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_en,
    input  logic [ADDR_W_DEF-1:0] bus_wr_addr,
    input  logic [DATA_W-1:0]     bus_wr_data,
    input  logic [ADDR_W_DEF-1:0] bus_rd_addr,
    output logic [DATA_W-1:0]     bus_rd_data,
    input  logic                  eie_set_vld,
    input  logic [CH_W-1:0]       eie_set_ch,
    input  logic                  eie_clr_vld,
    input  logic [CH_W-1:0]       eie_clr_ch,
    input  logic [NCH-1:0]        hw_req,
    input  logic [NCH-1:0]        major_done,
    input  logic [NCH-1:0]        dis_req,
    input  logic [NCH-1:0]        err_flag,
    output logic [NCH-1:0]        req_out,
    output logic [NCH-1:0]        err_irq
);
    logic           wr_reqen;
    logic           wr_errie;
    logic [NCH-1:0] req_en;
    logic [NCH-1:0] eie;
    logic [NCH-1:0] wr_bits;

    assign wr_bits = bus_wr_data[NCH-1:0];

    dma_rqe_decode #(.NCH(NCH), .DATA_W(DATA_W)) u_decode (
        .wr_en    (bus_wr_en),
        .wr_addr  (bus_wr_addr),
        .rd_addr  (bus_rd_addr),
        .req_en   (req_en),
        .eie      (eie),
        .wr_reqen (wr_reqen),
        .wr_errie (wr_errie),
        .rd_data  (bus_rd_data)
    );

    dma_rqe_reqbank #(.NCH(NCH)) u_reqbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_reqen   (wr_reqen),
        .wr_bits    (wr_bits),
        .major_done (major_done),
        .dis_req    (dis_req),
        .hw_req     (hw_req),
        .req_en     (req_en),
        .req_out    (req_out)
    );

    dma_rqe_eiebank #(.NCH(NCH), .CH_W(CH_W)) u_eiebank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_errie (wr_errie),
        .wr_bits  (wr_bits),
        .set_vld  (eie_set_vld),
        .set_ch   (eie_set_ch),
        .clr_vld  (eie_clr_vld),
        .clr_ch   (eie_clr_ch),
        .err_flag (err_flag),
        .eie      (eie),
        .err_irq  (err_irq)
    );
endmodule

// File: rtl/dma_rqe_ctrl_chk.sv
`timescale 1ns/1ps
module dma_rqe_ctrl_chk
    import dma_rqe_pkg::*;
#(
    parameter int unsigned NCH    = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CH_W   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr_en,
    input logic [ADDR_W_DEF-1:0] bus_wr_addr,
    input logic [DATA_W-1:0]     bus_rd_data,
    input logic                  eie_set_vld,
    input logic [CH_W-1:0]       eie_set_ch,
    input logic                  eie_clr_vld,
    input logic [CH_W-1:0]       eie_clr_ch,
    input logic [NCH-1:0]        hw_req,
    input logic [NCH-1:0]        major_done,
    input logic [NCH-1:0]        dis_req,
    input logic [NCH-1:0]        err_flag,
    input logic [NCH-1:0]        req_out,
    input logic [NCH-1:0]        err_irq,
    input logic [NCH-1:0]        req_en,
    input logic [NCH-1:0]        eie
);
    logic [NCH-1:0] kill;
    logic           wr_req_hit;
    logic           wr_eie_hit;
    assign kill       = major_done & dis_req;
    assign wr_req_hit = bus_wr_en && (bus_wr_addr == ADDR_REQEN);
    assign wr_eie_hit = bus_wr_en && (bus_wr_addr == ADDR_ERRIE);

    // R2: upper half of any read is zero
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_data[DATA_W-1:NCH] == '0);

    // R3: gated requests follow the enables
    p_req_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out & ~req_en) == '0 && (hw_req & req_en) == req_out);

    // R4, R5: completed channels with the flag set are off next cycle
    p_autoclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kill != '0) |=> ((req_en & $past(kill)) == '0));

    // R4: without a word write, bits not auto-cleared hold
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req_hit |=> ((req_en & ~$past(kill)) == ($past(req_en) & ~$past(kill))));

    // R7: clear strobe always lands
    p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eie_clr_vld |=> !eie[$past(eie_clr_ch)]);

    // R7: set strobe lands unless the same channel is cleared
    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eie_set_vld && !(eie_clr_vld && eie_clr_ch == eie_set_ch)) |=> eie[$past(eie_set_ch)]);

    // R8: interrupt needs both flag and enable
    p_irq_and_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == (err_flag & eie));

    // R9: no write to the enable map and no strobe leaves it unchanged
    p_eie_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_eie_hit && !eie_set_vld && !eie_clr_vld) |=> $stable(eie));
endmodule

bind dma_rqe_ctrl dma_rqe_ctrl_chk #(.NCH(NCH), .DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_addr (bus_wr_addr),
    .bus_rd_data (bus_rd_data),
    .eie_set_vld (eie_set_vld),
    .eie_set_ch  (eie_set_ch),
    .eie_clr_vld (eie_clr_vld),
    .eie_clr_ch  (eie_clr_ch),
    .hw_req      (hw_req),
    .major_done  (major_done),
    .dis_req     (dis_req),
    .err_flag    (err_flag),
    .req_out     (req_out),
    .err_irq     (err_irq),
    .req_en      (req_en),
    .eie         (eie)
);

// File: tb/dma_rqe_ctrl_bench.sv
`timescale 1ns/1ps
module dma_rqe_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_wr_addr = '0;
    logic [31:0] bus_wr_data = '0;
    logic [7:0]  bus_rd_addr = '0;
    logic [31:0] bus_rd_data;
    logic        eie_set_vld = 1'b0;
    logic [3:0]  eie_set_ch = '0;
    logic        eie_clr_vld = 1'b0;
    logic [3:0]  eie_clr_ch = '0;
    logic [15:0] hw_req = '0;
    logic [15:0] major_done = '0;
    logic [15:0] dis_req = '0;
    logic [15:0] err_flag = '0;
    logic [15:0] req_out;
    logic [15:0] err_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dma_rqe_ctrl u_dma_rqe_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
        .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
        .eie_set_vld(eie_set_vld), .eie_set_ch(eie_set_ch),
        .eie_clr_vld(eie_clr_vld), .eie_clr_ch(eie_clr_ch),
        .hw_req(hw_req), .major_done(major_done), .dis_req(dis_req),
        .err_flag(err_flag), .req_out(req_out), .err_irq(err_irq)
    );

    // behavioural reference state
    bit m_req [16];
    bit m_eie [16];

    function automatic logic [15:0] pack(input bit a [16]);
        logic [15:0] v = '0;
        for (int i = 0; i < 16; i++) v[i] = a[i];
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a == 8'h0C) return {16'h0, pack(m_req)};
        if (a == 8'h14) return {16'h0, pack(m_eie)};
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin m_req[i] = 0; m_eie[i] = 0; end
        end else begin
            if (bus_wr_en && bus_wr_addr == 8'h0C)
                for (int i = 0; i < 16; i++) m_req[i] = bus_wr_data[i];
            for (int i = 0; i < 16; i++)
                if (major_done[i] && dis_req[i]) m_req[i] = 0;
            if (bus_wr_en && bus_wr_addr == 8'h14)
                for (int i = 0; i < 16; i++) m_eie[i] = bus_wr_data[i];
            if (eie_set_vld) m_eie[eie_set_ch] = 1;
            if (eie_clr_vld) m_eie[eie_clr_ch] = 0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 req_out", {16'h0, req_out}, {16'h0, hw_req & pack(m_req)});
            check("R8 err_irq", {16'h0, err_irq}, {16'h0, err_flag & pack(m_eie)});
            check("R2/R6/R9 read", bus_rd_data, model_read(bus_rd_addr));
        end
    end

    task automatic idle();
        bus_wr_en = 0; eie_set_vld = 0; eie_clr_vld = 0; major_done = '0;
    endtask

    task automatic tick();
        @(posedge clk); #1; idle();
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr_en = 1; bus_wr_addr = a; bus_wr_data = d;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_rd_addr = a; #1;
        check(tag, bus_rd_data, exp);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        rd_check("R1 reqen after reset", 8'h0C, 32'h0);
        rd_check("R1 errie after reset", 8'h14, 32'h0);
        hw_req = '1; err_flag = '1; #1;
        check("R1 req_out after reset", {16'h0, req_out}, 32'h0);
        check("R1 err_irq after reset", {16'h0, err_irq}, 32'h0);
        rst_n = 1;
        tick();

        // R2: word write, upper half ignored
        bus_wr(8'h0C, 32'hFFFF_A5C3); tick();
        rd_check("R2 reqen readback", 8'h0C, 32'h0000_A5C3);
        // R3: gating
        hw_req = 16'hFFFF; #1;
        check("R3 gate all", {16'h0, req_out}, 32'h0000_A5C3);
        hw_req = 16'h0F0F; #1;
        check("R3 gate mixed", {16'h0, req_out}, 32'h0000_0503);

        // R4: auto-clear with flag, hold without
        major_done = 16'h0003; dis_req = 16'h0001; tick();
        rd_check("R4 auto clear ch0 keep ch1", 8'h0C, 32'h0000_A5C2);

        // R5: auto-clear beats simultaneous word write
        bus_wr(8'h0C, 32'h0000_FFFF); major_done = 16'h0080; dis_req = 16'h0080; tick();
        rd_check("R5 clear wins over write", 8'h0C, 32'h0000_FF7F);

        // R6: error-interrupt word write
        bus_wr(8'h14, 32'hABCD_00F0); tick();
        rd_check("R6 errie readback", 8'h14, 32'h0000_00F0);

        // R7: set, clear, collision
        eie_set_vld = 1; eie_set_ch = 4'd2; tick();
        rd_check("R7 set ch2", 8'h14, 32'h0000_00F4);
        eie_clr_vld = 1; eie_clr_ch = 4'd4; tick();
        rd_check("R7 clear ch4", 8'h14, 32'h0000_00E4);
        eie_set_vld = 1; eie_set_ch = 4'd9; eie_clr_vld = 1; eie_clr_ch = 4'd9; tick();
        rd_check("R7 same channel clear wins", 8'h14, 32'h0000_00E4);
        eie_set_vld = 1; eie_set_ch = 4'd15; eie_clr_vld = 1; eie_clr_ch = 4'd5; tick();
        rd_check("R7 two channels", 8'h14, 32'h0000_80C4);

        // R8: interrupt AND
        err_flag = 16'h80F0; #1;
        check("R8 irq", {16'h0, err_irq}, 32'h0000_80C0);

        // R9: unmapped writes ignored, unmapped reads zero
        bus_wr(8'h10, 32'h0000_FFFF); tick();
        bus_wr(8'h1A, 32'h0000_0000); tick();
        rd_check("R9 reqen untouched", 8'h0C, 32'h0000_FF7F);
        rd_check("R9 errie untouched", 8'h14, 32'h0000_80C4);
        rd_check("R9 unmapped read", 8'h10, 32'h0);

        // R10: strobes win over word write on their channel
        bus_wr(8'h14, 32'h0000_0101); eie_set_vld = 1; eie_set_ch = 4'd3;
        eie_clr_vld = 1; eie_clr_ch = 4'd8; tick();
        rd_check("R10 strobe over word", 8'h14, 32'h0000_0009);

        // random traffic compared every cycle
        for (int k = 0; k < 2000; k++) begin
            int pick;
            pick = $urandom_range(0, 5);
            bus_wr_en   = ($urandom_range(0, 2) == 0);
            bus_wr_addr = (pick == 0) ? 8'h0C : (pick == 1) ? 8'h14 : (pick == 2) ? 8'h10 :
                          (pick == 3) ? 8'h1B : (pick == 4) ? 8'h0C : 8'h14;
            bus_wr_data = $urandom;
            eie_set_vld = ($urandom_range(0, 3) == 0);
            eie_set_ch  = 4'($urandom_range(0, 15));
            eie_clr_vld = ($urandom_range(0, 3) == 0);
            eie_clr_ch  = ($urandom_range(0, 3) == 0) ? eie_set_ch : 4'($urandom_range(0, 15));
            hw_req      = 16'($urandom);
            major_done  = 16'($urandom) & 16'($urandom);
            dis_req     = 16'($urandom);
            err_flag    = 16'($urandom);
            bus_rd_addr = ($urandom_range(0, 1) == 0) ? 8'h0C :
                          ($urandom_range(0, 1) == 0) ? 8'h14 : 8'($urandom);
            @(posedge clk); #1;
        end
        idle();
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule